// File: doc/BRIEF.md
# Reorder Buffer Branch Resolver

This block is a small reorder buffer that keeps in-flight instructions in program order, with the oldest at slot 0. Each entry records its instruction address and whether it is a conditional branch or a plain instruction. A branch entry also stores the address it would jump to and the next address that fetch guessed. When execution writes the branch's condition value, the block works out the real successor. It then either deletes only that branch, or cuts the buffer off at the branch and steers fetch to the correct address.

The branch is of the jump-if-zero type. A zero condition value means the branch is taken, and a nonzero value means it falls through to its own address plus one. A correct guess closes the gap in the buffer within one cycle and leaves fetch alone. A wrong guess raises a one-cycle redirect and a one-cycle predictor update. A wrong guess is held back while the hold input is high. Hold stands for younger work that is still waiting on a memory or execution response.

Entries are named by an identifier that is handed out at allocation, so execution can find an entry after the buffer has shifted. Plain entries are marked complete by the same write port, and a completed plain entry at the head leaves the buffer.

Top module: `rob_branch_resolver`

## Requirements
- R1: While reset is active and in the first cycles after it, occupancy is 0, alloc_ready is 1, alloc_id is 0, and redir_valid and upd_valid are both 0.
- R2: An accepted allocation is appended behind all existing entries. It takes the lowest identifier not held by a live entry, which alloc_id shows beforehand. An allocation is refused when occupancy is DEPTH (8), and alloc_ready is then 0. An allocation made in a cycle whose misprediction squashes the buffer is dropped.
- R3: A write with wr_id equal to a live branch's identifier stores wr_value as that branch's condition value. The same write to a live plain entry marks the entry complete. A write to an identifier held by no live entry changes nothing.
- R4: A branch with condition value 0 is taken, and its real next address is its jump target.
- R5: A branch with a nonzero condition value is not taken, and its real next address is its own address plus one, modulo 2^AW.
- R6: When the predicted address equals the real next address, only that branch is removed. Older and younger entries keep their order, occupancy drops by one in the next cycle, and no redirect or update is raised.
- R7: On a wrong prediction, the branch and every younger entry are discarded. In the next cycle occupancy equals the branch's former slot index, and redir_valid pulses for one cycle with redir_addr equal to the real next address.
- R8: In the same cycle as the redirect, upd_valid pulses for one cycle with upd_addr equal to the branch address and upd_next equal to the real next address.
- R9: While hold is 1, a wrong prediction is not acted on, and no other branch resolves in that cycle. The squash happens on the first clock edge at which hold is 0.
- R10: At most one branch resolves per cycle. The ready branch at the lowest slot (the oldest) is the one that resolves.
- R11: In a cycle in which no branch is removed or squashes, a completed plain entry at the head is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Request to append an entry |
| alloc_branch | input | 1 | New entry is a branch (1) or plain (0) |
| alloc_addr | input | AW | Instruction address of the new entry |
| alloc_target | input | AW | Jump target of a new branch |
| alloc_pred | input | AW | Next address fetch used after the new branch |
| alloc_ready | output | 1 | Buffer has room |
| alloc_id | output | IDW | Identifier the next accepted entry receives |
| wr_valid | input | 1 | Result write strobe |
| wr_id | input | IDW | Identifier of the written entry |
| wr_value | input | VW | Condition value for a branch |
| hold | input | 1 | Younger work still outstanding; delays a squash |
| redir_valid | output | 1 | One-cycle fetch redirect |
| redir_addr | output | AW | Address fetch restarts from |
| upd_valid | output | 1 | One-cycle predictor update |
| upd_addr | output | AW | Address of the mispredicted branch |
| upd_next | output | AW | Real next address of that branch |
| occupancy | output | CNTW | Number of live entries |

## Verification
Branches are resolved as taken and as not taken, each with a correct and a wrong guess, so the target and fall-through paths each land in both the keep and the squash outcomes. A correct branch sitting between plain entries shows whether a middle deletion keeps the order. Two branches that become ready under hold show whether the oldest one wins when hold drops. Filling the buffer, allocating during a squash, and writing to an identifier no entry holds separate the refusal paths from the normal append. A reference queue model predicts occupancy, the next identifier and every redirect and update on each clock.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_KEEP   = 2'd1,
    ACT_SQUASH = 2'd2,
    ACT_RETIRE = 2'd3
  } rob_act_e;
endpackage

// File: rtl/rob_pick.sv
module rob_pick #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int VW    = 16,
  parameter int IXW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_q,
  input  logic [DEPTH-1:0] vld,
  input  logic [DEPTH-1:0] br,
  input  logic [DEPTH-1:0] rdy,
  input  logic [AW-1:0]    addr [DEPTH],
  input  logic [AW-1:0]    tgt  [DEPTH],
  input  logic [AW-1:0]    pred [DEPTH],
  input  logic [VW-1:0]    val  [DEPTH],
  output logic             found,
  output logic [IXW-1:0]   idx,
  output logic             correct,
  output logic [AW-1:0]    next_addr,
  output logic [AW-1:0]    br_addr
);
  logic [DEPTH-1:0] cand;

  always_comb begin
    cand  = vld & br & rdy;
    found = 1'b0;
    idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IXW'(i);
      end
    end
  end

  always_comb begin
    br_addr   = addr[idx];
    next_addr = (val[idx] == '0) ? tgt[idx] : addr[idx] + AW'(1);
    correct   = (pred[idx] == next_addr);
  end

  // R10: the chosen slot is a live ready branch
  assert_pick_live_R10: assert property (@(posedge clk) disable iff (!rst_q)
    found |-> (vld[idx] && br[idx] && rdy[idx]));
endmodule

// File: rtl/rob_id_free.sv
module rob_id_free #(
  parameter int DEPTH = 8,
  parameter int IDW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_q,
  input  logic [DEPTH-1:0] vld,
  input  logic [IDW-1:0]   id [DEPTH],
  output logic             any_free,
  output logic [IDW-1:0]   free_id
);
  logic [DEPTH-1:0] used;

  always_comb begin
    used = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i]) used[id[i]] = 1'b1;
    end
  end

  always_comb begin
    any_free = 1'b0;
    free_id  = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (!used[k]) begin
        any_free = 1'b1;
        free_id  = IDW'(k);
      end
    end
  end

  // R2: identifiers of live entries are distinct
  assert_id_unique_R2: assert property (@(posedge clk) disable iff (!rst_q)
    any_free == ($countones(vld) < DEPTH));
endmodule

// File: rtl/rob_branch_resolver.sv
module rob_branch_resolver #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int VW    = 16,
  parameter int IDW   = $clog2(DEPTH),
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_valid,
  input  logic            alloc_branch,
  input  logic [AW-1:0]   alloc_addr,
  input  logic [AW-1:0]   alloc_target,
  input  logic [AW-1:0]   alloc_pred,
  output logic            alloc_ready,
  output logic [IDW-1:0]  alloc_id,
  input  logic            wr_valid,
  input  logic [IDW-1:0]  wr_id,
  input  logic [VW-1:0]   wr_value,
  input  logic            hold,
  output logic            redir_valid,
  output logic [AW-1:0]   redir_addr,
  output logic            upd_valid,
  output logic [AW-1:0]   upd_addr,
  output logic [AW-1:0]   upd_next,
  output logic [CNTW-1:0] occupancy
);
  import rob_pkg::*;

  localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

  // reset synchronizer: asserted at once, released on the clock
  logic [1:0] rs_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  // entry state
  logic [DEPTH-1:0] e_vld, e_br, e_rdy, e_done;
  logic [IDW-1:0]   e_id   [DEPTH];
  logic [AW-1:0]    e_addr [DEPTH];
  logic [AW-1:0]    e_tgt  [DEPTH];
  logic [AW-1:0]    e_pred [DEPTH];
  logic [VW-1:0]    e_val  [DEPTH];
  logic [CNTW-1:0]  cnt_q;

  logic [DEPTH-1:0] n_vld, n_br, n_rdy, n_done;
  logic [IDW-1:0]   n_id   [DEPTH];
  logic [AW-1:0]    n_addr [DEPTH];
  logic [AW-1:0]    n_tgt  [DEPTH];
  logic [AW-1:0]    n_pred [DEPTH];
  logic [VW-1:0]    n_val  [DEPTH];
  logic [CNTW-1:0]  cnt_d;

  logic [DEPTH-1:0] w_rdy, w_done, w_hit;
  logic [VW-1:0]    w_val [DEPTH];

  logic             pk_found, pk_correct;
  logic [IDW-1:0]   pk_idx;
  logic [AW-1:0]    pk_next, pk_baddr;
  logic             id_any;
  logic [IDW-1:0]   id_free;

  rob_act_e         act;
  logic             rm_one, squash, alloc_take, st_en;
  logic [IDW-1:0]   rm_idx;
  logic [CNTW-1:0]  base;

  logic             redir_q, upd_q;
  logic [AW-1:0]    redir_addr_q, upd_addr_q, upd_next_q;

  rob_pick #(.DEPTH(DEPTH), .AW(AW), .VW(VW), .IXW(IDW)) u_pick (
    .clk       (clk),
    .rst_q     (rst_q),
    .vld       (e_vld),
    .br        (e_br),
    .rdy       (e_rdy),
    .addr      (e_addr),
    .tgt       (e_tgt),
    .pred      (e_pred),
    .val       (e_val),
    .found     (pk_found),
    .idx       (pk_idx),
    .correct   (pk_correct),
    .next_addr (pk_next),
    .br_addr   (pk_baddr)
  );

  rob_id_free #(.DEPTH(DEPTH), .IDW(IDW)) u_ids (
    .clk      (clk),
    .rst_q    (rst_q),
    .vld      (e_vld),
    .id       (e_id),
    .any_free (id_any),
    .free_id  (id_free)
  );

  assign alloc_ready = (cnt_q < FULL);
  assign alloc_id    = id_free;

  // action decision for this cycle
  always_comb begin
    act = ACT_NONE;
    if (pk_found && pk_correct)     act = ACT_KEEP;
    else if (pk_found && !hold && !pk_correct) act = ACT_SQUASH;
    else if (!pk_found || hold) begin
      if (e_vld[0] && !e_br[0] && e_done[0]) act = ACT_RETIRE;
    end
    squash     = (act == ACT_SQUASH);
    rm_one     = (act == ACT_KEEP) || (act == ACT_RETIRE);
    rm_idx     = (act == ACT_KEEP) ? pk_idx : '0;
    alloc_take = alloc_valid && alloc_ready && !squash;
    base       = squash ? CNTW'(pk_idx) : (cnt_q - CNTW'(rm_one));
    cnt_d      = base + CNTW'(alloc_take);
  end

  // result writes applied by identifier
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      w_hit[i]  = wr_valid && e_vld[i] && (e_id[i] == wr_id);
      w_rdy[i]  = e_rdy[i]  | (w_hit[i] & e_br[i]);
      w_done[i] = e_done[i] | (w_hit[i] & ~e_br[i]);
      w_val[i]  = (w_hit[i] && e_br[i]) ? wr_value : e_val[i];
    end
  end

  // compaction, truncation and append
  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      int src;
      src = j;
      if (rm_one && (j >= int'(rm_idx))) src = j + 1;
      if (src < DEPTH) begin
        n_vld[j]  = e_vld[src];
        n_br[j]   = e_br[src];
        n_rdy[j]  = w_rdy[src];
        n_done[j] = w_done[src];
        n_id[j]   = e_id[src];
        n_addr[j] = e_addr[src];
        n_tgt[j]  = e_tgt[src];
        n_pred[j] = e_pred[src];
        n_val[j]  = w_val[src];
      end else begin
        n_vld[j]  = 1'b0;
        n_br[j]   = 1'b0;
        n_rdy[j]  = 1'b0;
        n_done[j] = 1'b0;
        n_id[j]   = '0;
        n_addr[j] = '0;
        n_tgt[j]  = '0;
        n_pred[j] = '0;
        n_val[j]  = '0;
      end
      if (squash && (j >= int'(pk_idx))) n_vld[j] = 1'b0;
      if (alloc_take && (j == int'(base))) begin
        n_vld[j]  = 1'b1;
        n_br[j]   = alloc_branch;
        n_rdy[j]  = 1'b0;
        n_done[j] = 1'b0;
        n_id[j]   = id_free;
        n_addr[j] = alloc_addr;
        n_tgt[j]  = alloc_target;
        n_pred[j] = alloc_pred;
        n_val[j]  = '0;
      end
    end
    st_en = rm_one || squash || alloc_take || (|w_hit);
  end

  // control registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      e_vld  <= '0;
      e_br   <= '0;
      e_rdy  <= '0;
      e_done <= '0;
      cnt_q  <= '0;
      redir_q <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      if (st_en) begin
        e_vld  <= n_vld;
        e_br   <= n_br;
        e_rdy  <= n_rdy;
        e_done <= n_done;
        cnt_q  <= cnt_d;
      end
      redir_q <= squash;
      upd_q   <= squash;
    end
  end

  // data registers, no reset
  always_ff @(posedge clk) begin
    if (st_en) begin
      e_id   <= n_id;
      e_addr <= n_addr;
      e_tgt  <= n_tgt;
      e_pred <= n_pred;
      e_val  <= n_val;
    end
    if (squash) begin
      redir_addr_q <= pk_next;
      upd_addr_q   <= pk_baddr;
      upd_next_q   <= pk_next;
    end
  end

  assign redir_valid = redir_q;
  assign redir_addr  = redir_addr_q;
  assign upd_valid   = upd_q;
  assign upd_addr    = upd_addr_q;
  assign upd_next    = upd_next_q;
  assign occupancy   = cnt_q;

  assert_occ_bound_R2: assert property (@(posedge clk) disable iff (!rst_q)
    occupancy <= FULL);

  assert_full_refuse_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (occupancy == FULL) |=> (occupancy <= $past(occupancy)));

  assert_squash_shrink_R7: assert property (@(posedge clk) disable iff (!rst_q)
    redir_valid |-> (occupancy < $past(occupancy)));

  assert_redir_upd_R8: assert property (@(posedge clk) disable iff (!rst_q)
    redir_valid |-> (upd_valid && (upd_next == redir_addr)));

  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_q)
    hold |=> !redir_valid);
endmodule

// File: tb/rob_branch_resolver_bench.sv
module rob_branch_resolver_bench;
  localparam int DEPTH = 8;
  localparam int AW    = 16;
  localparam int VW    = 16;
  localparam int IDW   = 3;
  localparam int CNTW  = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            alloc_valid, alloc_branch;
  logic [AW-1:0]   alloc_addr, alloc_target, alloc_pred;
  logic            alloc_ready;
  logic [IDW-1:0]  alloc_id;
  logic            wr_valid;
  logic [IDW-1:0]  wr_id;
  logic [VW-1:0]   wr_value;
  logic            hold;
  logic            redir_valid, upd_valid;
  logic [AW-1:0]   redir_addr, upd_addr, upd_next;
  logic [CNTW-1:0] occupancy;

  always #10 clk = ~clk;

  rob_branch_resolver #(.DEPTH(DEPTH), .AW(AW), .VW(VW)) u_rob_branch_resolver (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_branch(alloc_branch),
    .alloc_addr(alloc_addr), .alloc_target(alloc_target), .alloc_pred(alloc_pred),
    .alloc_ready(alloc_ready), .alloc_id(alloc_id),
    .wr_valid(wr_valid), .wr_id(wr_id), .wr_value(wr_value),
    .hold(hold),
    .redir_valid(redir_valid), .redir_addr(redir_addr),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_next(upd_next),
    .occupancy(occupancy)
  );

  typedef struct {
    int id; bit br; int addr; int tgt; int pred; int val; bit rdy; bit done;
  } ment_t;

  ment_t q[$];
  int checks = 0;
  int bad = 0;
  string tag = "R1";
  bit e_rv, e_uv;
  int e_ra, e_ua, e_un;

  function automatic int model_free();
    for (int k = 0; k < DEPTH; k++) begin
      bit used = 0;
      foreach (q[i]) if (q[i].id == k) used = 1;
      if (!used) return k;
    end
    return 0;
  endfunction

  task automatic model_step();
    int f = -1;
    int nxt = 0;
    bit keep = 0, sq = 0, ret = 0;
    int fid = model_free();
    int pre = q.size();
    ment_t ne;
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].br && q[i].rdy) begin f = i; break; end
    end
    if (f >= 0) begin
      nxt = (q[f].val == 0) ? q[f].tgt : ((q[f].addr + 1) & 16'hFFFF);
      if (q[f].pred == nxt) keep = 1;
      else if (!hold) sq = 1;
    end
    if (!keep && !sq && pre > 0 && !q[0].br && q[0].done) ret = 1;
    e_rv = sq; e_uv = sq;
    if (sq) begin e_ra = nxt; e_ua = q[f].addr; e_un = nxt; end
    if (wr_valid) begin
      foreach (q[i]) if (q[i].id == int'(wr_id)) begin
        if (q[i].br) begin q[i].val = int'(wr_value); q[i].rdy = 1; end
        else q[i].done = 1;
      end
    end
    if (keep) q.delete(f);
    else if (ret) q.delete(0);
    else if (sq) while (q.size() > f) q.pop_back();
    if (alloc_valid && pre < DEPTH && !sq) begin
      ne.id = fid; ne.br = alloc_branch; ne.addr = int'(alloc_addr);
      ne.tgt = int'(alloc_target); ne.pred = int'(alloc_pred);
      ne.val = 0; ne.rdy = 0; ne.done = 0;
      q.push_back(ne);
    end
  endtask

  task automatic chk(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
    end
  endtask

  task automatic compare();
    chk("occupancy", int'(occupancy), q.size());
    chk("alloc_ready", int'(alloc_ready), (q.size() < DEPTH) ? 1 : 0);
    if (q.size() < DEPTH) chk("alloc_id", int'(alloc_id), model_free());
    chk("redir_valid", int'(redir_valid), int'(e_rv));
    chk("upd_valid", int'(upd_valid), int'(e_uv));
    if (e_rv) begin
      chk("redir_addr", int'(redir_addr), e_ra);
      chk("upd_addr", int'(upd_addr), e_ua);
      chk("upd_next", int'(upd_next), e_un);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1 model_step();
    @(negedge clk);
    compare();
    alloc_valid = 0;
    wr_valid = 0;
  endtask

  task automatic alloc1(bit br, int a, int t, int p, output int id);
    id = model_free();
    alloc_valid = 1; alloc_branch = br;
    alloc_addr = AW'(a); alloc_target = AW'(t); alloc_pred = AW'(p);
    tick();
  endtask

  task automatic wr1(int id, int v);
    wr_valid = 1; wr_id = IDW'(id); wr_value = VW'(v);
    tick();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int a, b, c, d;
    e_rv = 0; e_uv = 0; e_ra = 0; e_ua = 0; e_un = 0;
    alloc_valid = 0; alloc_branch = 0; alloc_addr = 0; alloc_target = 0; alloc_pred = 0;
    wr_valid = 0; wr_id = 0; wr_value = 0; hold = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1;
    tag = "R1"; idle(4);

    // taken, correct guess, removed from the middle; then retire
    tag = "R6";
    alloc1(0, 10, 0, 0, a);
    alloc1(1, 11, 40, 40, b);
    alloc1(0, 12, 0, 0, c);
    tag = "R4"; wr1(b, 0); idle(1);
    tag = "R11"; wr1(c, 1); idle(1); wr1(a, 1); idle(2);

    // not taken, correct guess
    tag = "R5";
    alloc1(1, 20, 50, 21, a);
    wr1(a, 5); idle(2);

    // taken, wrong guess with younger entries
    tag = "R7";
    alloc1(0, 29, 0, 0, d);
    alloc1(1, 30, 60, 31, a);
    alloc1(0, 31, 0, 0, b);
    alloc1(0, 32, 0, 0, c);
    tag = "R8"; wr1(a, 0); idle(2);
    tag = "R11"; wr1(d, 1); idle(1);

    // not taken, wrong guess; all-ones address wraps
    tag = "R5";
    alloc1(1, 70, 90, 90, a);
    alloc1(0, 71, 0, 0, b);
    wr1(a, 3); idle(2);
    tag = "R5";
    alloc1(1, 16'hFFFF, 9, 9, a);
    wr1(a, 1); idle(2);

    // hold delays the squash
    tag = "R9";
    alloc1(1, 100, 200, 101, a);
    alloc1(0, 101, 0, 0, b);
    hold = 1;
    wr1(a, 0); idle(3);
    hold = 0; idle(2);

    // oldest ready branch wins
    tag = "R10";
    alloc1(1, 300, 400, 301, a);
    alloc1(1, 310, 500, 500, b);
    alloc1(0, 320, 0, 0, c);
    hold = 1;
    wr1(b, 7); wr1(a, 0); idle(1);
    hold = 0; idle(2);

    // unknown identifier is ignored
    tag = "R3";
    alloc1(0, 600, 0, 0, a);
    wr1(5, 1); idle(2);
    wr1(a, 1); idle(1);

    // fill and refuse
    tag = "R2";
    for (int i = 0; i < DEPTH; i++) alloc1(0, 700 + i, 0, 0, a);
    alloc1(0, 799, 0, 0, a); idle(1);
    for (int i = DEPTH - 1; i >= 0; i--) wr1(i, 1);
    idle(DEPTH + 1);

    // allocation dropped during a squash
    tag = "R2";
    alloc1(1, 800, 900, 801, a);
    alloc1(0, 801, 0, 0, b);
    wr1(a, 0);
    alloc1(0, 802, 0, 0, c); idle(2);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule